// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a non-pipelined processor core for a 32-bit integer instruction subset. It retires one instruction on every clock edge. The core fetches from a separate instruction memory port and decodes the word into a single record. It reads two source registers and computes the result, the effective address and the next program counter. On the next edge it commits everything at once: the program counter, the register file and the data memory.

Both memories sit outside the core. They are read combinationally and written on the clock edge. The instruction port and the data port are independent, so loads and stores also take one cycle.

When the core decodes an encoding it does not support, it raises a sticky flag. From then on it stops changing any state until the next reset. Integration code can use the flag as a halt indication.

Top module: `rv_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) sets the program counter to 0, clears all 31 writable registers to zero and clears `illegal`.
- R2: Register 0 always reads as zero. An instruction naming register 0 as its destination leaves every register unchanged.
- R3: Register-register operations (opcode 0110011) are decoded from funct3 (bits 14:12): 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 shift right, 110 or, 111 and. With bit 30 set, 000 selects subtract and 101 selects an arithmetic shift right. Shifts use the low 5 bits of the second operand.
- R4: Register-immediate operations (opcode 0010011) use the same funct3 map with the sign-extended 12-bit immediate in bits 31:20, except that subtract does not exist. The shifts take their amount from bits 24:20, and bit 30 selects the arithmetic right shift.
- R5: LUI (0110111) writes the 20-bit immediate in bits 31:12 shifted left by 12. AUIPC (0010111) writes the program counter plus that same value.
- R6: JAL (1101111) and JALR (1100111, funct3 000) write the program counter plus 4 to rd. JAL jumps to pc plus the J-immediate. JALR jumps to rs1 plus the I-immediate, with bit 0 cleared.
- R7: Conditional branches (1100011) compare rs1 with rs2 using funct3 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. When the condition holds, the next pc is pc plus the B-immediate.
- R8: LW (0000011, funct3 010) writes the addressed memory word to rd. SW (0100011, funct3 010) writes rs2 to memory at rs1 plus the S-immediate. The two low bits of the effective address are ignored.
- R9: Any other opcode, any other load, store or JALR funct3, branch funct3 010 or 011, or a funct7 other than the ones allowed by R3 and R4 sets `illegal`. The flag stays set, and from the edge that decodes such an instruction onward the pc, the registers and the memory no longer change.
- R10: Every non-control instruction that retires advances the program counter by exactly 4, in one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Program counter, fetch address |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Word-aligned data address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable for this edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |
| illegal | output | 1 | Sticky unsupported-instruction flag |

## Verification
Register contents are not visible at the ports. The hardest thing to show is therefore each operation's exact result for operand pairs that separate signed from unsigned behaviour and arithmetic from logical behaviour. For every pair of eight edge values, the bench assembles a fresh program that loads the operands, runs every operation and branch, and stores each result to its own data word. Each run ends in a different unsupported encoding, followed by a store that must never happen.

// File: rtl/rvc_pkg.sv
// Package: shared widths, opcode values and the decoded-instruction record
// of the single-cycle core. Assumes a 32-bit integer instruction subset.
package rvc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int SHW  = $clog2(XLEN);

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;

    typedef enum logic [2:0] {
        IT_BAD, IT_ALU, IT_LD, IT_ST, IT_JAL, IT_JALR, IT_BR, IT_AUIPC
    } kind_e;

    typedef enum logic [3:0] {
        AF_ADD, AF_SUB, AF_AND, AF_OR, AF_XOR,
        AF_SLT, AF_SLTU, AF_SLL, AF_SRL, AF_SRA
    } alu_e;

    typedef struct packed {
        kind_e            kind;
        alu_e             alu;
        logic [2:0]       cmp;
        logic             wr_en;
        logic [RIDX-1:0]  rd;
        logic [RIDX-1:0]  rs1;
        logic [RIDX-1:0]  rs2;
        logic             use_imm;
        logic [XLEN-1:0]  imm;
    } dec_t;
endpackage

// File: rtl/rv_decode.sv
// Decoder: turns one instruction word into the decoded record.
// Assumes: purely combinational; unsupported encodings yield kind IT_BAD
// with no register write.
module rv_decode
    import rvc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            d
);
    logic [6:0]      opc;
    logic [2:0]      f3;
    logic [6:0]      f7;
    logic            wr;
    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

    assign opc   = instr[6:0];
    assign f3    = instr[14:12];
    assign f7    = instr[31:25];
    assign imm_i = {{20{instr[31]}}, instr[31:20]};
    assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    assign imm_u = {instr[31:12], 12'b0};
    assign imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

    // maps funct3 and the alternate bit to an ALU operation
    function automatic alu_e alu_of(input logic [2:0] f, input logic alt);
        case (f)
            3'b000:  return alt ? AF_SUB : AF_ADD;
            3'b001:  return AF_SLL;
            3'b010:  return AF_SLT;
            3'b011:  return AF_SLTU;
            3'b100:  return AF_XOR;
            3'b101:  return alt ? AF_SRA : AF_SRL;
            3'b110:  return AF_OR;
            default: return AF_AND;
        endcase
    endfunction

    // builds the decoded record from the opcode group and legality checks
    always_comb begin
        d.kind    = IT_BAD;
        d.alu     = AF_ADD;
        d.cmp     = f3;
        d.rd      = instr[11:7];
        d.rs1     = instr[19:15];
        d.rs2     = instr[24:20];
        d.use_imm = 1'b1;
        d.imm     = imm_i;
        wr        = 1'b0;
        case (opc)
            OPC_OP: begin
                d.use_imm = 1'b0;
                d.alu     = alu_of(f3, instr[30]);
                wr        = 1'b1;
                if (f7 == 7'b0000000 || (f7 == 7'b0100000 && (f3 == 3'b000 || f3 == 3'b101)))
                    d.kind = IT_ALU;
            end
            OPC_OPIMM: begin
                d.alu = alu_of(f3, (f3 == 3'b101) && instr[30]);
                wr    = 1'b1;
                if ((f3 == 3'b001 && f7 != 7'b0000000) ||
                    (f3 == 3'b101 && f7 != 7'b0000000 && f7 != 7'b0100000))
                    d.kind = IT_BAD;
                else
                    d.kind = IT_ALU;
            end
            OPC_LUI: begin
                d.kind = IT_ALU;
                d.rs1  = '0;
                d.imm  = imm_u;
                wr     = 1'b1;
            end
            OPC_AUIPC: begin
                d.kind = IT_AUIPC;
                d.imm  = imm_u;
                wr     = 1'b1;
            end
            OPC_JAL: begin
                d.kind = IT_JAL;
                d.imm  = imm_j;
                wr     = 1'b1;
            end
            OPC_JALR: begin
                if (f3 == 3'b000) d.kind = IT_JALR;
                wr = 1'b1;
            end
            OPC_BRANCH: begin
                d.use_imm = 1'b0;
                d.imm     = imm_b;
                if (f3 != 3'b010 && f3 != 3'b011) d.kind = IT_BR;
            end
            OPC_LOAD: begin
                if (f3 == 3'b010) d.kind = IT_LD;
                wr = 1'b1;
            end
            OPC_STORE: begin
                d.imm = imm_s;
                if (f3 == 3'b010) d.kind = IT_ST;
            end
            default: d.kind = IT_BAD;
        endcase
        d.wr_en = wr && (d.kind != IT_BAD) && (d.rd != '0);
    end
endmodule

// File: rtl/rv_regfile.sv
// Register file: two combinational read ports, one write port on the edge.
// Assumes: entry 0 is held at zero; reset is synchronous and active-low.
module rv_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RIDX-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RIDX-1:0] raddr_a,
    input  logic [RIDX-1:0] raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] regs [NREG];

    // clears all entries on reset, otherwise writes the addressed non-zero entry
    always_ff @(posedge clk) begin
        regs[0] <= '0;
        for (int i = 1; i < NREG; i++) begin
            if (!rst_n)                          regs[i] <= '0;
            else if (we && waddr == RIDX'(i))    regs[i] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/rv_exec.sv
// Execute stage: ALU, branch compare, result select and next-pc choice.
// Assumes: purely combinational; operands already read from the register file.
module rv_exec
    import rvc_pkg::*;
(
    input  kind_e           kind,
    input  alu_e            alu,
    input  logic [2:0]      cmp,
    input  logic            use_imm,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] rv2,
    output logic [XLEN-1:0] result,
    output logic [XLEN-1:2] ea_word,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] b, alu_res, pc4;
    logic [SHW-1:0]  sh;
    logic            taken;

    assign b   = use_imm ? imm : rv2;
    assign sh  = b[SHW-1:0];
    assign pc4 = pc + XLEN'(4);

    // arithmetic and logic unit
    always_comb begin
        case (alu)
            AF_SUB:  alu_res = a - b;
            AF_AND:  alu_res = a & b;
            AF_OR:   alu_res = a | b;
            AF_XOR:  alu_res = a ^ b;
            AF_SLT:  alu_res = XLEN'($signed(a) < $signed(b));
            AF_SLTU: alu_res = XLEN'(a < b);
            AF_SLL:  alu_res = a << sh;
            AF_SRL:  alu_res = a >> sh;
            AF_SRA:  alu_res = XLEN'($signed(a) >>> sh);
            default: alu_res = a + b;
        endcase
    end

    // branch condition from funct3
    always_comb begin
        case (cmp)
            3'b000:  taken = (a == rv2);
            3'b001:  taken = (a != rv2);
            3'b100:  taken = ($signed(a) < $signed(rv2));
            3'b101:  taken = ($signed(a) >= $signed(rv2));
            3'b110:  taken = (a < rv2);
            default: taken = (a >= rv2);
        endcase
    end

    // register write value and next program counter
    always_comb begin
        case (kind)
            IT_JAL, IT_JALR: result = pc4;
            IT_AUIPC:        result = pc + imm;
            default:         result = alu_res;
        endcase
        case (kind)
            IT_JAL:  next_pc = pc + imm;
            IT_JALR: next_pc = (a + imm) & ~XLEN'(1);
            IT_BR:   next_pc = taken ? pc + imm : pc4;
            default: next_pc = pc4;
        endcase
    end

    assign ea_word = alu_res[XLEN-1:2];
endmodule

// File: rtl/rv_core.sv
// Single-cycle core top: program counter, halt flag and the wiring of
// decode, register file and execute. Assumes combinational-read memories
// outside the block; all state commits on one clock edge.
module rv_core
    import rvc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            illegal
);
    logic [XLEN-1:0] pc_q, rv1, rv2, result, next_pc, wdata;
    logic [XLEN-1:2] ea_word;
    logic            illegal_q, halt;
    dec_t            d;

    rv_decode u_dec (.instr(imem_rdata), .d(d));

    rv_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(!halt && d.wr_en), .waddr(d.rd), .wdata(wdata),
        .raddr_a(d.rs1), .raddr_b(d.rs2),
        .rdata_a(rv1), .rdata_b(rv2)
    );

    rv_exec u_ex (
        .kind(d.kind), .alu(d.alu), .cmp(d.cmp), .use_imm(d.use_imm), .imm(d.imm),
        .pc(pc_q), .a(rv1), .rv2(rv2),
        .result(result), .ea_word(ea_word), .next_pc(next_pc)
    );

    assign halt       = illegal_q || (d.kind == IT_BAD);
    assign wdata      = (d.kind == IT_LD) ? dmem_rdata : result;
    assign dmem_addr  = {ea_word, 2'b00};
    assign dmem_wdata = rv2;
    assign dmem_we    = !halt && (d.kind == IT_ST);
    assign imem_addr  = pc_q;
    assign illegal    = illegal_q;

    // program counter: holds once halted
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (!halt) pc_q <= next_pc;
    end

    // sticky unsupported-instruction flag
    always_ff @(posedge clk) begin
        if (!rst_n)                 illegal_q <= 1'b0;
        else if (d.kind == IT_BAD)  illegal_q <= 1'b1;
    end
endmodule

// File: rtl/rv_core_chk.sv
// Checker for rv_core: port-level temporal properties; bound below.
module rv_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [6:0]  opc,
    input logic [2:0]  f3,
    input logic        dmem_we,
    input logic        illegal
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'd0 && !illegal));                                   // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);                                                     // R9
    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(pc));                                                 // R9
    AST_NO_STORE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !dmem_we);                                                    // R9
    AST_UPPER_IMM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && (opc == 7'b0110111 || opc == 7'b0010111)) |=> pc == $past(pc) + 32'd4); // R10
    AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && opc == 7'b0100011 && f3 == 3'b010) |-> dmem_we);             // R8
endmodule

bind rv_core rv_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pc(imem_addr),
    .opc(imem_rdata[6:0]), .f3(imem_rdata[14:12]),
    .dmem_we(dmem_we), .illegal(illegal)
);

// File: tb/rv_core_bench.sv
// Bench: for every pair of eight edge values, assembles a program, runs it
// to an unsupported terminator and checks the stored results.
module rv_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mem_clr = 1'b1;
    always #5 clk = ~clk;

    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, illegal;
    logic [31:0] imem [128];
    logic [31:0] dmem [64];
    localparam logic [31:0] FILL = 32'hA5A5_5A5A;
    localparam logic [6:0]  B_OP = 7'b0110011, B_OPI = 7'b0010011, B_LUI = 7'b0110111,
                            B_AUI = 7'b0010111, B_JALR = 7'b1100111, B_LD = 7'b0000011;

    int checks = 0;
    int fails  = 0;
    int wp, ns, term_pc;
    logic [31:0] expv [64];
    string       tags [64];

    rv_core u_rv_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .illegal(illegal)
    );

    assign imem_rdata = imem[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (mem_clr) for (int i = 0; i < 64; i++) dmem[i] <= FILL;
        else if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                          logic [4:0] rd, logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] rs2, logic [4:0] rs1,
                                          logic [2:0] f3);
        return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] rd);
        return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    // store register r into the next result slot and record what it must hold
    task automatic sw_chk(input logic [4:0] r, input logic [31:0] e, input string t);
        emit(enc_s(12'(ns * 4), r, 5'd0, 3'b010));
        expv[ns] = e;
        tags[ns] = t;
        ns++;
    endtask

    task automatic li(input logic [4:0] r, input logic [31:0] v);
        logic [31:0] hi;
        hi = (v + 32'h800) >> 12;
        emit({hi[19:0], r, B_LUI});
        emit(enc_i(v[11:0], r, 3'b000, r, B_OPI));
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", t, act, e);
        end
    endtask

    function automatic logic [31:0] r_exp(int k, logic [31:0] a, logic [31:0] b);
        case (k)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return {31'd0, $signed(a) < $signed(b)};
            6: return {31'd0, a < b};
            7: return a << b[4:0];
            8: return a >> b[4:0];
            default: return 32'($signed(a) >>> b[4:0]);
        endcase
    endfunction
    function automatic logic [31:0] r_ins(int k);
        logic [2:0] f;
        logic [6:0] s;
        f = (k == 0 || k == 1) ? 3'b000 : (k == 2) ? 3'b111 : (k == 3) ? 3'b110 :
            (k == 4) ? 3'b100 : (k == 5) ? 3'b010 : (k == 6) ? 3'b011 :
            (k == 7) ? 3'b001 : 3'b101;
        s = (k == 1 || k == 9) ? 7'b0100000 : 7'b0000000;
        return enc_r(s, 5'd2, 5'd1, f, 5'd3, B_OP);
    endfunction

    localparam logic [11:0] IM_A = 12'hFFB, IM_L = 12'h5A3;
    function automatic logic [31:0] i_exp(int k, logic [31:0] a);
        logic [31:0] sa, sl;
        sa = {{20{IM_A[11]}}, IM_A};
        sl = {{20{IM_L[11]}}, IM_L};
        case (k)
            0: return a + sa;
            1: return {31'd0, $signed(a) < $signed(sa)};
            2: return {31'd0, a < sa};
            3: return a ^ sl;
            4: return a | sl;
            5: return a & sl;
            6: return a << 7;
            7: return a >> 7;
            default: return 32'($signed(a) >>> 7);
        endcase
    endfunction
    function automatic logic [31:0] i_ins(int k);
        case (k)
            0: return enc_i(IM_A, 5'd1, 3'b000, 5'd3, B_OPI);
            1: return enc_i(IM_A, 5'd1, 3'b010, 5'd3, B_OPI);
            2: return enc_i(IM_A, 5'd1, 3'b011, 5'd3, B_OPI);
            3: return enc_i(IM_L, 5'd1, 3'b100, 5'd3, B_OPI);
            4: return enc_i(IM_L, 5'd1, 3'b110, 5'd3, B_OPI);
            5: return enc_i(IM_L, 5'd1, 3'b111, 5'd3, B_OPI);
            6: return enc_i(12'd7, 5'd1, 3'b001, 5'd3, B_OPI);
            7: return enc_i(12'd7, 5'd1, 3'b101, 5'd3, B_OPI);
            default: return enc_i({7'b0100000, 5'd7}, 5'd1, 3'b101, 5'd3, B_OPI);
        endcase
    endfunction

    function automatic logic [2:0] br_f3(int k);
        case (k)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b100;
            3: return 3'b101;
            4: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction
    function automatic logic br_taken(int k, logic [31:0] a, logic [31:0] b);
        case (k)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) < $signed(b);
            3: return $signed(a) >= $signed(b);
            4: return a < b;
            default: return a >= b;
        endcase
    endfunction

    function automatic logic [31:0] term_ins(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return enc_i(12'd0, 5'd1, 3'b000, 5'd5, B_LD);
            2: return enc_s(12'd0, 5'd1, 5'd0, 3'b001);
            3: return enc_b(13'd8, 5'd2, 5'd1, 3'b010);
            4: return enc_r(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, B_OP);
            5: return enc_i(12'd0, 5'd1, 3'b001, 5'd3, B_JALR);
            default: return enc_i({7'b0100000, 5'd3}, 5'd1, 3'b001, 5'd3, B_OPI);
        endcase
    endfunction

    task automatic build(input logic [31:0] a, input logic [31:0] b, input int kind);
        int p;
        wp = 0;
        ns = 0;
        for (int i = 0; i < 128; i++) imem[i] = 32'h0;
        sw_chk(5'd20, 32'd0, "R1 reg cleared by reset");
        li(5'd1, a);
        li(5'd2, b);
        for (int k = 0; k < 10; k++) begin
            emit(r_ins(k));
            sw_chk(5'd3, r_exp(k, a, b), $sformatf("R3 op%0d", k));
        end
        for (int k = 0; k < 9; k++) begin
            emit(i_ins(k));
            sw_chk(5'd3, i_exp(k, a), $sformatf("R4 op%0d", k));
        end
        emit(enc_i(12'd5, 5'd1, 3'b000, 5'd0, B_OPI));
        sw_chk(5'd0, 32'd0, "R2 x0 write ignored");
        emit({20'hABCDE, 5'd4, B_LUI});
        sw_chk(5'd4, 32'hABCDE000, "R5 lui");
        p = wp * 4;
        emit({20'h00012, 5'd5, B_AUI});
        sw_chk(5'd5, 32'(p) + 32'h12000, "R5 auipc");
        for (int k = 0; k < 6; k++) begin
            emit(enc_i(12'd0, 5'd0, 3'b000, 5'd14, B_OPI));
            emit(enc_b(13'd8, 5'd2, 5'd1, br_f3(k)));
            emit(enc_i(12'd1, 5'd0, 3'b000, 5'd14, B_OPI));
            sw_chk(5'd14, br_taken(k, a, b) ? 32'd0 : 32'd1, $sformatf("R7 br%0d", k));
        end
        p = wp * 4;
        emit(enc_j(21'd8, 5'd6));
        emit(enc_i(12'd1, 5'd0, 3'b000, 5'd7, B_OPI));
        sw_chk(5'd6, 32'(p) + 32'd4, "R6 jal link");
        sw_chk(5'd7, 32'd0, "R6 jal skip");
        p = wp * 4;
        emit({20'h0, 5'd8, B_AUI});
        emit(enc_i(12'd13, 5'd8, 3'b000, 5'd9, B_JALR));
        emit(enc_i(12'd1, 5'd0, 3'b000, 5'd10, B_OPI));
        sw_chk(5'd9, 32'(p) + 32'd8, "R6 jalr link");
        sw_chk(5'd10, 32'd0, "R6 jalr bit0 cleared target");
        emit(enc_i(12'd6, 5'd0, 3'b010, 5'd11, B_LD));
        sw_chk(5'd11, a + b, "R8 lw low bits ignored");
        emit(enc_i(12'd77, 5'd0, 3'b000, 5'd20, B_OPI));
        term_pc = wp * 4;
        emit(term_ins(kind));
        emit(enc_s(12'd252, 5'd1, 5'd0, 3'b010));
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input int kind);
        int cnt;
        @(negedge clk);
        rst_n   = 1'b0;
        mem_clr = 1'b1;
        build(a, b, kind);
        @(negedge clk);
        @(negedge clk);
        chk(imem_addr, 32'd0, "R1 pc after reset");
        chk({31'd0, illegal}, 32'd0, "R1 flag after reset");
        mem_clr = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        chk(imem_addr, 32'd4, "R10 pc step");
        cnt = 0;
        while (!illegal && cnt < 400) begin
            @(negedge clk);
            cnt++;
        end
        if (!illegal) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog act=%h exp=%h", imem_addr, term_pc);
        end
        chk(imem_addr, 32'(term_pc), $sformatf("R9 halt pc term%0d", kind));
        repeat (4) @(negedge clk);
        chk(imem_addr, 32'(term_pc), "R9 pc frozen");
        chk({31'd0, illegal}, 32'd1, "R9 flag sticky");
        for (int i = 0; i < ns; i++) chk(dmem[i], expv[i], tags[i]);
        chk(dmem[63], FILL, "R9 no store after halt");
    endtask

    logic [31:0] vals [8];
    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h1234_5678;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                run(vals[i], vals[j], (i * 8 + j) % 7);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule